// File: doc/BRIEF.md
# Embedded-Sync Interlaced Video Word Generator

This block drives a slave-mode video encoder with a single 8-bit word stream at one word per clock. The nominal rate is 27 million words per second. There are no separate sync wires. Line and field timing travel inside the stream as four-word timing reference codes. One code closes the active part of every line and another opens it. Every other blanking slot carries blank-level filler. Each line holds twice as many word slots as pixel periods, because colour is subsampled 4:2:2. Lines are counted across two interlaced fields.

During the active part of a picture line, the block asks an upstream frame-buffer reader for one pixel pair at a time. It sends the pair as chroma-blue, first luma, chroma-red, second luma. The upstream side sees a ready/valid pair, but the video timing never waits. `px_ready` pulses for one clock, and the source must present the pair with `px_valid` high in the very next clock. If `px_valid` is low in that clock, the four slots of that group are sent as blank level. `px_valid` in any other clock is ignored. No back-pressure ever reaches the generator.

All timing is set by parameters: pixels per line, active pixels, lines per frame, the line where each field starts, and the lines that bound each vertical blanking band. The defaults describe the standard 525-line, 858-pixel raster.

Top module: `bt656_stream_gen`

## Requirements
- R1: Each line is exactly 2*LINE_PIX word slots long. Its slot 0 is the 0xFF that begins the end-of-active code, so consecutive line heads are 2*LINE_PIX clocks apart.
- R2: Lines run 1..FRAME_LINES and then wrap to 1. `frame_start` is high for exactly the one clock in which `vid_data` carries slot 0 of line 1.
- R3: A timing code is the four words 0xFF, 0x00, 0x00, status. The end-of-active code fills slots 0..3. The start-of-active code fills the four slots just before the first active slot, at BLANK-4..BLANK-1 where BLANK = 2*(LINE_PIX-ACT_PIX). The status word has bit 4 (H) equal to 1 in the end-of-active code and 0 in the start-of-active code.
- R4: The status word is {1, F, V, H, V^H, F^H, F^V, F^V^H}. F is 1 on lines below F0_LINE and on lines from F1_LINE upward. V is 1 on lines below V_ACT0 and on lines from V_BLK1 up to V_ACT1-1.
- R5: The horizontal blanking slots between the two codes alternate 0x80 and 0x10, starting with 0x80 after the end-of-active code.
- R6: On a line with V=0, the active slots carry pixel pairs as repeating groups of Cb, Y0, Cr, Y1.
- R7: `px_ready` is high for one clock, exactly one clock before the first slot of each group, and only on lines with V=0. That gives ACT_PIX/2 pulses per picture line.
- R8: On a line with V=1, both codes are still sent. The active slots carry 0x80/0x10 alternating from 0x80, and `px_ready` stays low.
- R9: Luma is limited to 16..235 and chroma to 16..240. As a result, 0x00 and 0xFF appear only inside timing codes.
- R10: If `px_valid` is low in the clock after `px_ready`, the group is sent as 0x80, 0x10, 0x80, 0x10. `px_valid` and pair data outside that clock do not affect the stream.
- R11: A synchronous reset holds `vid_data` at 0x80 and `frame_start` low. After release, the stream restarts at slot 0 of line 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous reset, active high |
| px_valid | input | 1 | Pixel pair present, honoured only in the clock after `px_ready` |
| px_cb | input | 8 | Blue colour-difference sample of the pair |
| px_y0 | input | 8 | Luma of the first pixel |
| px_cr | input | 8 | Red colour-difference sample of the pair |
| px_y1 | input | 8 | Luma of the second pixel |
| px_ready | output | 1 | Request for the next pixel pair, one clock ahead |
| vid_data | output | 8 | Multiplexed video word stream |
| frame_start | output | 1 | Marks the first word of line 1 |

## Verification
The hardest case to reach from the ports is a reset in the middle of a picture line. At that moment the pair store and the request logic hold partial state, and a request may have been issued but not yet answered. The bench runs a shrunk raster through three full frames so that it covers every field and blanking band. It then asserts reset partway into a line, checks the reset words, and requires the restarted stream to match a fresh frame word for word. The source answers requests with out-of-range samples, sometimes leaves a request unanswered, and drives `px_valid` high with reserved-value garbage in every clock outside the answer slot.

// File: rtl/bt656_pkg.sv
package bt656_pkg;

  localparam logic [7:0] CODE_HI = 8'hFF;
  localparam logic [7:0] CODE_LO = 8'h00;
  localparam logic [7:0] FILL_C  = 8'h80;
  localparam logic [7:0] FILL_Y  = 8'h10;
  localparam logic [7:0] Y_MIN   = 8'd16;
  localparam logic [7:0] Y_MAX   = 8'd235;
  localparam logic [7:0] C_MIN   = 8'd16;
  localparam logic [7:0] C_MAX   = 8'd240;

  // Region of the line the slot counter is in.
  typedef enum logic [1:0] {
    SEG_EAV   = 2'd0,
    SEG_HFILL = 2'd1,
    SEG_SAV   = 2'd2,
    SEG_PIX   = 2'd3
  } seg_t;

  // Remainder of a pixel pair after its chroma-blue word has gone out.
  typedef struct packed {
    logic [7:0] y0;
    logic [7:0] cr;
    logic [7:0] y1;
  } held_t;

  function automatic logic [7:0] status_word(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  function automatic logic [7:0] limit(input logic [7:0] x, input logic [7:0] lo,
                                       input logic [7:0] hi);
    if (x < lo) return lo;
    if (x > hi) return hi;
    return x;
  endfunction

endpackage

// File: rtl/bt656_line_timer.sv
module bt656_line_timer
  import bt656_pkg::*;
#(
  parameter int LINE_PIX    = 858,
  parameter int ACT_PIX     = 720,
  parameter int FRAME_LINES = 525,
  parameter int F0_LINE     = 4,
  parameter int F1_LINE     = 266,
  parameter int V_ACT0      = 20,
  parameter int V_BLK1      = 264,
  parameter int V_ACT1      = 283,
  parameter int WORD_W      = 11,
  parameter int LINE_W      = 10
) (
  input  logic       clk,
  input  logic       rst,
  output seg_t       seg,
  output logic [1:0] code_pos,
  output logic [1:0] phase,
  output logic       w_odd,
  output logic       fld,
  output logic       vblk,
  output logic       frame_head,
  output logic       grp_open,
  output logic       req_next
);

  localparam int LINE_WORDS  = 2 * LINE_PIX;
  localparam int BLANK_WORDS = 2 * (LINE_PIX - ACT_PIX);
  localparam logic [WORD_W-1:0] LAST_W   = WORD_W'(LINE_WORDS - 1);
  localparam logic [WORD_W-1:0] SAV_W    = WORD_W'(BLANK_WORDS - 4);
  localparam logic [WORD_W-1:0] PIX_W    = WORD_W'(BLANK_WORDS);
  localparam logic [WORD_W-1:0] PRE_W    = WORD_W'(BLANK_WORDS - 1);
  localparam logic [1:0]        BLANK_LO = 2'(BLANK_WORDS % 4);
  localparam logic [LINE_W-1:0] LAST_L   = LINE_W'(FRAME_LINES);

  logic [WORD_W-1:0] w_q;
  logic [LINE_W-1:0] l_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      w_q <= '0;
      l_q <= LINE_W'(1);
    end else if (w_q == LAST_W) begin
      w_q <= '0;
      l_q <= (l_q == LAST_L) ? LINE_W'(1) : l_q + LINE_W'(1);
    end else begin
      w_q <= w_q + WORD_W'(1);
    end
  end

  always_comb begin
    if (w_q < WORD_W'(4))   seg = SEG_EAV;
    else if (w_q < SAV_W)   seg = SEG_HFILL;
    else if (w_q < PIX_W)   seg = SEG_SAV;
    else                    seg = SEG_PIX;
  end

  assign phase      = w_q[1:0] - BLANK_LO;
  assign code_pos   = (seg == SEG_EAV) ? w_q[1:0] : phase;
  assign w_odd      = w_q[0];
  assign fld        = (l_q < LINE_W'(F0_LINE)) || (l_q >= LINE_W'(F1_LINE));
  assign vblk       = (l_q < LINE_W'(V_ACT0)) ||
                      ((l_q >= LINE_W'(V_BLK1)) && (l_q < LINE_W'(V_ACT1)));
  assign frame_head = (l_q == LINE_W'(1)) && (w_q == '0);
  assign grp_open   = (seg == SEG_PIX) && (phase == 2'd0) && !vblk;
  assign req_next   = !vblk && (w_q != LAST_W) && (w_q >= PRE_W) && (phase == 2'd3);

endmodule

// File: rtl/bt656_pair_buffer.sv
module bt656_pair_buffer
  import bt656_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       load,
  input  logic       px_valid,
  input  logic [7:0] px_cb,
  input  logic [7:0] px_y0,
  input  logic [7:0] px_cr,
  input  logic [7:0] px_y1,
  output logic [7:0] cb_word,
  output held_t      held
);

  // Component order 0..3 = Cb, Y0, Cr, Y1; even slots are chroma.
  logic [3:0][7:0] raw;
  logic [3:0][7:0] lim;
  logic [3:0][7:0] blank;

  assign raw = {px_y1, px_cr, px_y0, px_cb};

  for (genvar i = 0; i < 4; i++) begin : g_comp
    if ((i % 2) == 0) begin : g_chroma
      assign lim[i]   = limit(raw[i], C_MIN, C_MAX);
      assign blank[i] = FILL_C;
    end else begin : g_luma
      assign lim[i]   = limit(raw[i], Y_MIN, Y_MAX);
      assign blank[i] = FILL_Y;
    end
  end

  assign cb_word = px_valid ? lim[0] : blank[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      held <= '{y0: FILL_Y, cr: FILL_C, y1: FILL_Y};
    end else if (load) begin
      held.y0 <= px_valid ? lim[1] : blank[1];
      held.cr <= px_valid ? lim[2] : blank[2];
      held.y1 <= px_valid ? lim[3] : blank[3];
    end
  end

endmodule

// File: rtl/bt656_word_mux.sv
module bt656_word_mux
  import bt656_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  seg_t       seg,
  input  logic [1:0] code_pos,
  input  logic [1:0] phase,
  input  logic       w_odd,
  input  logic       fld,
  input  logic       vblk,
  input  logic       frame_head,
  input  logic [7:0] cb_word,
  input  held_t      held,
  output logic [7:0] vid_data,
  output logic       frame_start
);

  logic [7:0] fill_word;
  logic [7:0] code_word;
  logic [7:0] pix_word;
  logic [7:0] next_word;

  assign fill_word = w_odd ? FILL_Y : FILL_C;

  always_comb begin
    unique case (code_pos)
      2'd0:    code_word = CODE_HI;
      2'd3:    code_word = status_word(fld, vblk, seg == SEG_EAV);
      default: code_word = CODE_LO;
    endcase
  end

  always_comb begin
    unique case (phase)
      2'd0:    pix_word = cb_word;
      2'd1:    pix_word = held.y0;
      2'd2:    pix_word = held.cr;
      default: pix_word = held.y1;
    endcase
  end

  always_comb begin
    unique case (seg)
      SEG_EAV, SEG_SAV: next_word = code_word;
      SEG_HFILL:        next_word = fill_word;
      default:          next_word = vblk ? fill_word : pix_word;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vid_data    <= FILL_C;
      frame_start <= 1'b0;
    end else begin
      vid_data    <= next_word;
      frame_start <= frame_head;
    end
  end

endmodule

// File: rtl/bt656_stream_gen.sv
module bt656_stream_gen
  import bt656_pkg::*;
#(
  parameter int LINE_PIX    = 858,
  parameter int ACT_PIX     = 720,
  parameter int FRAME_LINES = 525,
  parameter int F0_LINE     = 4,
  parameter int F1_LINE     = 266,
  parameter int V_ACT0      = 20,
  parameter int V_BLK1      = 264,
  parameter int V_ACT1      = 283
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       px_valid,
  input  logic [7:0] px_cb,
  input  logic [7:0] px_y0,
  input  logic [7:0] px_cr,
  input  logic [7:0] px_y1,
  output logic       px_ready,
  output logic [7:0] vid_data,
  output logic       frame_start
);

  localparam int WORD_W = $clog2(2 * LINE_PIX);
  localparam int LINE_W = $clog2(FRAME_LINES + 1);

  seg_t       seg;
  logic [1:0] code_pos;
  logic [1:0] phase;
  logic       w_odd;
  logic       fld;
  logic       vblk;
  logic       frame_head;
  logic       grp_open;
  logic [7:0] cb_word;
  held_t      held;

  bt656_line_timer #(
    .LINE_PIX(LINE_PIX), .ACT_PIX(ACT_PIX), .FRAME_LINES(FRAME_LINES),
    .F0_LINE(F0_LINE), .F1_LINE(F1_LINE), .V_ACT0(V_ACT0),
    .V_BLK1(V_BLK1), .V_ACT1(V_ACT1), .WORD_W(WORD_W), .LINE_W(LINE_W)
  ) u_timer (
    .clk(clk), .rst(rst), .seg(seg), .code_pos(code_pos), .phase(phase),
    .w_odd(w_odd), .fld(fld), .vblk(vblk), .frame_head(frame_head),
    .grp_open(grp_open), .req_next(px_ready)
  );

  bt656_pair_buffer u_pair (
    .clk(clk), .rst(rst), .load(grp_open), .px_valid(px_valid),
    .px_cb(px_cb), .px_y0(px_y0), .px_cr(px_cr), .px_y1(px_y1),
    .cb_word(cb_word), .held(held)
  );

  bt656_word_mux u_mux (
    .clk(clk), .rst(rst), .seg(seg), .code_pos(code_pos), .phase(phase),
    .w_odd(w_odd), .fld(fld), .vblk(vblk), .frame_head(frame_head),
    .cb_word(cb_word), .held(held), .vid_data(vid_data),
    .frame_start(frame_start)
  );

endmodule

// File: rtl/bt656_stream_gen_chk.sv
module bt656_stream_gen_chk #(
  parameter int LINE_WORDS = 1716
) (
  input logic       clk,
  input logic       rst,
  input logic       px_ready,
  input logic [7:0] vid_data,
  input logic       frame_start
);

  // Progress through a code preamble: 1 after 0xFF, 2 after 0xFF 0x00, 3 on the status word.
  logic [1:0]  stg_q;
  logic [15:0] gap_q;
  logic        seen_q;
  logic        eav_stat;

  assign eav_stat = (stg_q == 2'd3) && vid_data[4];

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_q  <= 2'd0;
      gap_q  <= 16'd0;
      seen_q <= 1'b0;
    end else begin
      if (vid_data == 8'hFF)                         stg_q <= 2'd1;
      else if ((stg_q == 2'd1) && (vid_data == 8'h00)) stg_q <= 2'd2;
      else if ((stg_q == 2'd2) && (vid_data == 8'h00)) stg_q <= 2'd3;
      else                                           stg_q <= 2'd0;
      if (eav_stat) begin
        gap_q  <= 16'd1;
        seen_q <= 1'b1;
      end else begin
        gap_q  <= gap_q + 16'd1;
      end
    end
  end

  p_preamble_r3: assert property (@(posedge clk) disable iff (rst)
    (vid_data == 8'hFF) |=> (vid_data == 8'h00));

  p_reserved_r9: assert property (@(posedge clk) disable iff (rst)
    (vid_data == 8'h00) |-> ((stg_q == 2'd1) || (stg_q == 2'd2)));

  p_status_prot_r4: assert property (@(posedge clk) disable iff (rst)
    (stg_q == 2'd3) |-> (vid_data[7] &&
      (vid_data[3:0] == {vid_data[5] ^ vid_data[4], vid_data[6] ^ vid_data[4],
                         vid_data[6] ^ vid_data[5], vid_data[6] ^ vid_data[5] ^ vid_data[4]})));

  p_line_len_r1: assert property (@(posedge clk) disable iff (rst)
    (eav_stat && seen_q) |-> (gap_q == 16'(LINE_WORDS)));

  p_frame_code_r2: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (vid_data == 8'hFF));

  p_req_gap_r7: assert property (@(posedge clk) disable iff (rst)
    px_ready |=> !px_ready);

endmodule

bind bt656_stream_gen bt656_stream_gen_chk #(.LINE_WORDS(2 * LINE_PIX)) u_chk (
  .clk(clk), .rst(rst), .px_ready(px_ready), .vid_data(vid_data),
  .frame_start(frame_start)
);

// File: tb/tb_bt656_stream_gen.sv
module tb_bt656_stream_gen;

  localparam int LP = 16, AP = 8, FL = 10;
  localparam int F0 = 2, F1 = 6, VA0 = 3, VB1 = 5, VA1 = 7;
  localparam int LW = 2 * LP;
  localparam int BLK = 2 * (LP - AP);
  localparam int FW = LW * FL;

  typedef struct {
    logic       fs;
    logic [7:0] d;
    string      tag;
  } exp_t;

  typedef struct {
    logic       ok;
    logic [7:0] cb, y0, cr, y1;
  } pair_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       px_valid = 1'b0;
  logic [7:0] px_cb = 8'h00, px_y0 = 8'h00, px_cr = 8'h00, px_y1 = 8'h00;
  logic       px_ready;
  logic [7:0] vid_data;
  logic       frame_start;

  int   checks = 0;
  int   fails = 0;
  int   req_seen = 0;
  int   src_k = 0;
  logic pend = 1'b0;
  logic mon_on = 1'b0;
  exp_t sb[$];

  always #5 clk = ~clk;

  bt656_stream_gen #(
    .LINE_PIX(LP), .ACT_PIX(AP), .FRAME_LINES(FL), .F0_LINE(F0),
    .F1_LINE(F1), .V_ACT0(VA0), .V_BLK1(VB1), .V_ACT1(VA1)
  ) dut (
    .clk(clk), .rst(rst), .px_valid(px_valid), .px_cb(px_cb), .px_y0(px_y0),
    .px_cr(px_cr), .px_y1(px_y1), .px_ready(px_ready), .vid_data(vid_data),
    .frame_start(frame_start)
  );

  function automatic pair_t gen_pair(int k);
    pair_t p;
    p.ok = (k % 5) != 3;
    p.cb = 8'(k * 29 + 5);
    p.y0 = 8'(k * 53 + 17);
    p.cr = 8'(k * 71 + 200);
    p.y1 = 8'(k * 13 + 240);
    if (k % 7 == 0) begin
      p.cb = 8'h00; p.y0 = 8'hFF; p.cr = 8'hFF; p.y1 = 8'h00;
    end
    return p;
  endfunction

  function automatic logic [7:0] lim(logic [7:0] x, logic [7:0] lo, logic [7:0] hi);
    return (x < lo) ? lo : ((x > hi) ? hi : x);
  endfunction

  function automatic logic [7:0] stat(int ln, logic h);
    logic f, v;
    f = (ln < F0) || (ln >= F1);
    v = (ln < VA0) || ((ln >= VB1) && (ln < VA1));
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  task automatic push(logic fs, logic [7:0] d, string tag);
    exp_t e;
    e.fs = fs; e.d = d; e.tag = tag;
    sb.push_back(e);
  endtask

  // Driver: expected word stream for n frames from line 1 slot 0.
  task automatic push_frames(int n, string first_tag);
    int k = 0;
    pair_t p;
    for (int f = 0; f < n; f++) begin
      for (int ln = 1; ln <= FL; ln++) begin
        logic vb;
        vb = (ln < VA0) || ((ln >= VB1) && (ln < VA1));
        for (int w = 0; w < LW; w++) begin
          logic fs;
          string t;
          logic [7:0] d;
          logic [7:0] raw;
          fs = (ln == 1) && (w == 0);
          if (w < 4 || (w >= BLK - 4 && w < BLK)) begin
            int c;
            c = (w < 4) ? w : w - (BLK - 4);
            d = (c == 0) ? 8'hFF : ((c == 3) ? stat(ln, w < 4) : 8'h00);
            t = (c == 3) ? "R4" : ((w == 0) ? "R1" : "R3");
          end else if (w < BLK) begin
            d = w[0] ? 8'h10 : 8'h80; t = "R5";
          end else if (vb) begin
            d = w[0] ? 8'h10 : 8'h80; t = "R8";
          end else begin
            int ph;
            ph = (w - BLK) % 4;
            if (ph == 0) begin p = gen_pair(k); k++; end
            case (ph)
              0: raw = p.cb;
              1: raw = p.y0;
              2: raw = p.cr;
              default: raw = p.y1;
            endcase
            if (!p.ok) begin
              d = w[0] ? 8'h10 : 8'h80; t = "R10";
            end else begin
              d = (ph % 2 == 0) ? lim(raw, 8'd16, 8'd240) : lim(raw, 8'd16, 8'd235);
              t = (d != raw) ? "R9" : "R6";
            end
          end
          if (fs) t = "R2";
          if (f == 0 && ln == 1 && w == 0) t = first_tag;
          push(fs, d, t);
        end
      end
    end
  endtask

  // Pixel source: answers one clock after a request; garbage with valid high otherwise.
  always @(negedge clk) begin
    if (rst) begin
      src_k <= 0; pend <= 1'b0;
      px_valid <= 1'b1; px_cb <= 8'hFF; px_y0 <= 8'hFF; px_cr <= 8'hFF; px_y1 <= 8'hFF;
    end else begin
      if (pend) begin
        pair_t p;
        p = gen_pair(src_k);
        px_valid <= p.ok;
        px_cb <= p.ok ? p.cb : 8'h00; px_y0 <= p.ok ? p.y0 : 8'hFF;
        px_cr <= p.ok ? p.cr : 8'h00; px_y1 <= p.ok ? p.y1 : 8'hFF;
        src_k <= src_k + 1;
      end else begin
        px_valid <= 1'b1; px_cb <= 8'h00; px_y0 <= 8'hFF; px_cr <= 8'h00; px_y1 <= 8'hFF;
      end
      pend <= px_ready;
    end
  end

  // Monitor: pops the scoreboard and compares each output word.
  always @(negedge clk) begin
    if (mon_on && sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      checks++;
      if (px_ready) req_seen++;
      if (vid_data !== e.d || frame_start !== e.fs) begin
        fails++;
        $display("FAIL %s: got fs=%0b data=%02h expected fs=%0b data=%02h",
                 e.tag, frame_start, vid_data, e.fs, e.d);
      end
    end
  end

  task automatic check_reset_state();
    checks++;
    if (vid_data !== 8'h80 || frame_start !== 1'b0 || px_ready !== 1'b0) begin
      fails++;
      $display("FAIL R11: got data=%02h fs=%0b ready=%0b expected data=80 fs=0 ready=0",
               vid_data, frame_start, px_ready);
    end
  endtask

  task automatic run_queue();
    @(posedge clk);
    mon_on = 1'b1;
    while (sb.size() != 0) @(negedge clk);
    mon_on = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check_reset_state();
    push_frames(3, "R11");
    rst = 1'b0;
    run_queue();
    checks++;
    if (req_seen != 3 * 6 * (AP / 2)) begin
      fails++;
      $display("FAIL R7: got %0d requests expected %0d", req_seen, 3 * 6 * (AP / 2));
    end
    // Reset partway into a picture line of the next frame.
    repeat (3 * LW + BLK + 5) @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check_reset_state();
    push_frames(1, "R11");
    rst = 1'b0;
    run_queue();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule